// File: doc/BRIEF.md
# Serial Remainder-Modulo-Three Tracker

The block takes a binary number one bit per clock, most significant bit first, and keeps the remainder of the value seen so far divided by three. The number is never stored. Each accepted bit folds into a two-bit state as `new = (2*old + bit) mod 3`, so numbers of any length are handled with the same three states. A synchronous reset starts a new number; the empty number has remainder 0.

The present remainder is always available on `remainder`. The `divisible` flag has two forms, chosen by the parameter `MEALY_OUT`. In the state-based form (`MEALY_OUT = 0`) it reports whether the stored remainder is 0, so it changes one clock after the bit that caused it. In the transition-based form (`MEALY_OUT = 1`) it reports, in the same cycle as a valid bit, whether the transition being taken lands on remainder 0. The unused state code 3 returns to remainder 0 on the next valid bit.

Top module: `mod3_serial`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes remainder 0; after that edge `remainder` reads 0 and the state-based `divisible` reads 1.
- R2: On a rising edge with `bitValid` high, the remainder (codes 0 = 00, 1 = 01, 2 = 10) moves as: 0 with bit 0 stays 0, 0 with bit 1 goes to 1, 1 with bit 0 goes to 2, 1 with bit 1 goes to 0, 2 with bit 0 goes to 1, 2 with bit 1 stays 2.
- R3: Feeding the bits 1,1,0,1,0,1,0 (value 106) from reset gives the remainders 1,0,0,1,2,2,1 after the successive bits.
- R4: With `MEALY_OUT = 0`, `divisible` is 1 exactly when the stored remainder is 0, and it changes only at a clock edge.
- R5: With `MEALY_OUT = 1`, `divisible` is 1 in a cycle exactly when `bitValid` is high and the transition taken at the next edge leads to remainder 0.
- R6: While `bitValid` is low the remainder holds through clock edges, and the transition-based `divisible` is 0.
- R7: There is no limit on the number length: after any number of accepted bits, `remainder` equals the full value modulo 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; starts a new number |
| bitValid | input | 1 | High when `bitIn` carries the next bit |
| bitIn | input | 1 | Serial data bit, most significant first |
| remainder | output | 2 | Present remainder of the number modulo 3 |
| divisible | output | 1 | Divisible-by-three flag, state-based or transition-based per `MEALY_OUT` |

## Verification
The assertions take for granted that `bitValid` and `bitIn` are stable and known around each rising edge and that the state never starts from the spare code 3 other than through reset. The stimulus changes inputs only on the falling edge, always begins with a reset, and feeds known bits, so the state reached is always one of the three legal remainders. Runs cover the 106 example, every transition from every state, idle gaps, a reset mid-number and a long pseudo-random stream compared with a behavioural model.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  localparam int REM_W = 2;
  typedef logic [REM_W-1:0] rem_t;

  localparam rem_t REM_ZERO  = 2'b00;
  localparam rem_t REM_ONE   = 2'b01;
  localparam rem_t REM_TWO   = 2'b10;
  localparam rem_t REM_SPARE = 2'b11;

  typedef struct packed {
    logic advance;
    logic recover;
    logic clear;
  } step_ctl_t;
endpackage

// File: rtl/mod3_ctrl.sv
module mod3_ctrl
  import mod3_pkg::*;
(
  input  logic      rst,
  input  logic      bitValid,
  input  rem_t      curRem,
  output step_ctl_t ctl
);
  always_comb begin
    ctl.clear   = rst;
    ctl.advance = bitValid && !rst;
    ctl.recover = (curRem == REM_SPARE);
  end
endmodule

// File: rtl/mod3_datapath.sv
module mod3_datapath
  import mod3_pkg::*;
(
  input  logic      clk,
  input  step_ctl_t ctl,
  input  logic      bitIn,
  output rem_t      curRem,
  output rem_t      nextRem
);
  rem_t stateQ;
  rem_t stepRem;

  always_comb begin
    unique case (stateQ)
      REM_ZERO: stepRem = bitIn ? REM_ONE  : REM_ZERO;
      REM_ONE:  stepRem = bitIn ? REM_ZERO : REM_TWO;
      REM_TWO:  stepRem = bitIn ? REM_TWO  : REM_ONE;
      default:  stepRem = REM_ZERO;
    endcase
  end

  always_comb begin
    if (ctl.clear)
      nextRem = REM_ZERO;
    else if (ctl.advance)
      nextRem = ctl.recover ? REM_ZERO : stepRem;
    else
      nextRem = stateQ;
  end

  always_ff @(posedge clk) begin
    stateQ <= nextRem;
  end

  assign curRem = stateQ;
endmodule

// File: rtl/mod3_serial.sv
module mod3_serial
  import mod3_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitValid,
  input  logic       bitIn,
  output logic [1:0] remainder,
  output logic       divisible
);
  step_ctl_t ctl;
  rem_t      curRem;
  rem_t      nextRem;

  mod3_ctrl ctrl_i (
    .rst      (rst),
    .bitValid (bitValid),
    .curRem   (curRem),
    .ctl      (ctl)
  );

  mod3_datapath dp_i (
    .clk     (clk),
    .ctl     (ctl),
    .bitIn   (bitIn),
    .curRem  (curRem),
    .nextRem (nextRem)
  );

  generate
    if (MEALY_OUT) begin : g_mealy
      assign divisible = ctl.advance && (nextRem == REM_ZERO);
    end else begin : g_moore
      assign divisible = (curRem == REM_ZERO);
    end
  endgenerate

  assign remainder = curRem;
endmodule

// File: rtl/mod3_serial_chk.sv
module mod3_serial_chk #(
  parameter bit MEALY_OUT = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       bitValid,
  input logic       bitIn,
  input logic [1:0] remainder,
  input logic       divisible
);
  logic prevRst;
  logic started;

  always_ff @(posedge clk) begin
    prevRst <= rst;
    started <= rst ? 1'b0 : 1'b1;
  end

  function automatic logic [1:0] fold(input logic [1:0] r, input logic b);
    return 2'((({30'd0, r} << 1) + {31'd0, b}) % 3);
  endfunction

  // R1: one edge after reset the remainder is 0
  always_ff @(posedge clk) begin
    if (prevRst === 1'b1) begin
      a_r1_reset_zero: assert (remainder == 2'b00);
    end
  end

  a_r2_fold: assert property (@(posedge clk) disable iff (rst)
    (started && bitValid) |=> (remainder == fold($past(remainder), $past(bitIn))));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (started && !bitValid) |=> $stable(remainder));

  generate
    if (MEALY_OUT) begin : g_mealy_chk
      a_r6_mealy_idle_low: assert property (@(posedge clk) disable iff (rst)
        !bitValid |-> !divisible);
      a_r5_mealy_lands_zero: assert property (@(posedge clk) disable iff (rst)
        (started && divisible) |=> (remainder == 2'b00));
    end else begin : g_moore_chk
      a_r4_moore_edge_only: assert property (@(posedge clk) disable iff (rst)
        (started && !bitValid) |=> $stable(divisible));
    end
  endgenerate
endmodule

bind mod3_serial mod3_serial_chk #(.MEALY_OUT(MEALY_OUT)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bitValid  (bitValid),
  .bitIn     (bitIn),
  .remainder (remainder),
  .divisible (divisible)
);

// File: tb/mod3_serial_tb_top.sv
`timescale 1ns/1ps
module mod3_serial_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic [1:0] remMoore, remMealy;
  logic divMoore, divMealy;

  int checks = 0;
  int fails = 0;
  int refRem = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mod3_serial #(.MEALY_OUT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn),
    .remainder(remMoore), .divisible(divMoore));

  mod3_serial #(.MEALY_OUT(1'b1)) dutMealy_i (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn),
    .remainder(remMealy), .divisible(divMealy));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive on the falling edge, check combinational view, then let the edge happen.
  task automatic step(input bit v, input bit b, input bit r, input string req);
    int nxt;
    @(negedge clk);
    rst = r; bitValid = v; bitIn = b;
    #1;
    nxt = (2 * refRem + b) % 3;
    check(req, "moore remainder", int'(remMoore), refRem);
    check(req, "mealy remainder", int'(remMealy), refRem);
    check("R4", "moore divisible", int'(divMoore), (refRem == 0) ? 1 : 0);
    check(v ? "R5" : "R6", "mealy divisible", int'(divMealy),
          (!r && v && nxt == 0) ? 1 : 0);
    @(posedge clk);
    if (r) refRem = 0;
    else if (v) refRem = nxt;
    #1;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit seq106 [7] = '{1, 1, 0, 1, 0, 1, 0};
    int exp106 [7] = '{1, 0, 0, 1, 2, 2, 1};
    step(0, 0, 1, "R1");
    step(0, 0, 1, "R1");
    check("R1", "remainder after reset", int'(remMoore), 0);
    check("R1", "moore divisible after reset", int'(divMoore), 1);

    // R3: value 106
    for (int i = 0; i < 7; i++) begin
      step(1, seq106[i], 0, "R3");
      check("R3", "remainder after bit", int'(remMoore), exp106[i]);
      check("R3", "mealy remainder after bit", int'(remMealy), exp106[i]);
    end

    // R6: idle gap holds remainder 1
    for (int i = 0; i < 4; i++) step(0, i[0], 0, "R6");
    check("R6", "held remainder", int'(remMoore), 1);

    // R2: every transition from every state
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 2; b++) begin
        step(0, 0, 1, "R2");
        if (s == 1) step(1, 1, 0, "R2");
        if (s == 2) begin step(1, 1, 0, "R2"); step(1, 0, 0, "R2"); end
        check("R2", "setup state", int'(remMoore), s);
        step(1, b[0], 0, "R2");
        check("R2", "transition target", int'(remMoore), (2 * s + b) % 3);
      end
    end

    // R1: reset in the middle of a number
    step(1, 1, 0, "R1");
    step(1, 0, 0, "R1");
    step(1, 1, 1, "R1");
    check("R1", "mid-number reset", int'(remMoore), 0);

    // R7: long stream with idle gaps
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, $urandom % 2, 0, "R7");
    end
    check("R7", "long stream remainder", int'(remMoore), refRem);
    for (int i = 0; i < 200; i++) step(1, 1, 0, "R7");
    check("R7", "all-ones tail", int'(remMealy), refRem);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule